// File: doc/BRIEF.md
# I2C Master Event Status Register

This block holds the event status of an I2C master as one 32-bit register word. The serial bus engine sends single-cycle event pulses, such as a NACK seen in an acknowledge slot, a lost arbitration or a stop it has driven. Each pulse raises a flag that stays set until software clears it. Software clears a flag by writing a 0 to its bit position. Writing a 1 leaves that bit as it is, so a routine can clear just the events it has handled without disturbing the others.

The block also owns the master-enable control bit. A lost arbitration drops this bit in hardware, which takes the master off the bus. The bit comes back only when software pulses a separate set input. A single interrupt request combines every flag with its own enable bit.

Top module: `i2cm_status`

## Requirements
- R1: Read data bits 31 to 7 are always 0, whatever value was written to them.
- R2: An event pulse in cycle k sets its flag, and the flag is visible on the read data after the clock edge that ends cycle k. It stays 1 through later cycles that carry no clearing write.
- R3: A write with a 0 in bit i (for i from 0 to 6) clears flag i when no event for that flag occurs in the same cycle. A 1 in bit i leaves flag i unchanged. Bits are cleared independently of each other.
- R4: If an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: Flag positions are: bit 6 NACK received, bit 5 arbitration lost, bit 4 stop sent, bit 3 data empty, bit 2 data transmitted, bit 1 data received, bit 0 address transmitted.
- R6: An arbitration-lost event sets bit 5 and, at the same edge, drives the master-enable output to 0.
- R7: Master enable becomes 1 only after a pulse on `men_set`, and stays 0 otherwise. If arbitration is lost in the same cycle as a `men_set` pulse, master enable ends up 0.
- R8: `irq` is 1 exactly when some flag i is 1 and `irq_en[i]` is 1. It follows both inputs without a register stage.
- R9: A synchronous active-high reset clears all seven flags and master enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; a 0 in bits 6..0 clears the flag |
| rd_data | output | 32 | Register read value |
| ev_nack | input | 1 | NACK seen after an address or data byte |
| ev_arb_lost | input | 1 | Arbitration lost to another master |
| ev_stop | input | 1 | Stop condition driven (forced or after NACK) |
| ev_data_empty | input | 1 | Transmit data empty |
| ev_data_tx | input | 1 | Data byte transmitted |
| ev_data_rx | input | 1 | Data byte received |
| ev_addr_tx | input | 1 | Address byte transmitted |
| irq_en | input | 7 | Per-flag interrupt enables, same bit order as flags |
| men_set | input | 1 | Software pulse that sets master enable |
| men | output | 1 | Master enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest cases to reach are the ones where two sources act in the same cycle. One is a clear-by-zero write that meets an event on the same flag. The other is a `men_set` pulse that meets a lost arbitration. The vector table drives a write and an event pulse in one step, which covers the first case. A directed step raises `men_set` and `ev_arb_lost` together, which covers the second. A separate directed step applies reset while flags are set.

// File: rtl/i2cm_stat_pkg.sv
package i2cm_stat_pkg;

    localparam int unsigned REG_W     = 32;
    localparam int unsigned NUM_FLAGS = 7;

    // Bit positions inside the register word (R5)
    localparam int unsigned BIT_NACK   = 6;
    localparam int unsigned BIT_ARB    = 5;
    localparam int unsigned BIT_STOP   = 4;
    localparam int unsigned BIT_DEMPTY = 3;
    localparam int unsigned BIT_DTX    = 2;
    localparam int unsigned BIT_DRX    = 1;
    localparam int unsigned BIT_ATX    = 0;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    // Packed so the declaration order matches the register bit order.
    typedef struct packed {
        logic nack;
        logic arb_lost;
        logic stop;
        logic data_empty;
        logic data_tx;
        logic data_rx;
        logic addr_tx;
    } i2cm_ev_t;

    typedef struct packed {
        logic                 wr;
        logic [REG_W-1:0]     data;
    } sw_wr_t;

    function automatic logic [REG_W-1:0] to_word(input flag_vec_t f);
        logic [REG_W-1:0] w;
        w = '0;
        w[NUM_FLAGS-1:0] = f;
        return w;
    endfunction

endpackage

// File: rtl/i2cm_flag_bank.sv
module i2cm_flag_bank
    import i2cm_stat_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sw_wr_t    sw,
    input  flag_vec_t ev,
    output flag_vec_t flags
);
    // One sticky cell per flag: an event sets the cell, a 0 written to its bit clears it
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_cell
        logic keep;
        assign keep = !(sw.wr && !sw.data[i]);
        always_ff @(posedge clk) begin
            if (rst) flags[i] <= 1'b0;
            else     flags[i] <= ev[i] | (flags[i] & keep);
        end
    end
endmodule

// File: rtl/i2cm_men_ctrl.sv
module i2cm_men_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic arb_lost,
    output logic men
);
    always_ff @(posedge clk) begin
        if (rst)           men <= 1'b0;
        else if (arb_lost) men <= 1'b0;
        else if (set_req)  men <= 1'b1;
    end
endmodule

// File: rtl/i2cm_irq_reduce.sv
module i2cm_irq_reduce
    import i2cm_stat_pkg::*;
(
    input  flag_vec_t flags,
    input  flag_vec_t en,
    output logic      irq
);
    assign irq = |(flags & en);
endmodule

// File: rtl/i2cm_status.sv
module i2cm_status
    import i2cm_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              ev_nack,
    input  logic              ev_arb_lost,
    input  logic              ev_stop,
    input  logic              ev_data_empty,
    input  logic              ev_data_tx,
    input  logic              ev_data_rx,
    input  logic              ev_addr_tx,
    input  logic [NUM_FLAGS-1:0] irq_en,
    input  logic              men_set,
    output logic              men,
    output logic              irq
);
    i2cm_ev_t  ev_s;
    sw_wr_t    sw_s;
    flag_vec_t flags;

    assign ev_s = '{nack:       ev_nack,
                    arb_lost:   ev_arb_lost,
                    stop:       ev_stop,
                    data_empty: ev_data_empty,
                    data_tx:    ev_data_tx,
                    data_rx:    ev_data_rx,
                    addr_tx:    ev_addr_tx};
    assign sw_s = '{wr: wr_en, data: wr_data};

    i2cm_flag_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .sw    (sw_s),
        .ev    (flag_vec_t'(ev_s)),
        .flags (flags)
    );

    i2cm_men_ctrl u_men (
        .clk      (clk),
        .rst      (rst),
        .set_req  (men_set),
        .arb_lost (ev_s.arb_lost),
        .men      (men)
    );

    i2cm_irq_reduce u_irq (
        .flags (flags),
        .en    (irq_en),
        .irq   (irq)
    );

    assign rd_data = to_word(flags);
endmodule

// File: rtl/i2cm_status_chk.sv
module i2cm_status_chk
    import i2cm_stat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [REG_W-1:0]  wr_data,
    input logic [REG_W-1:0]  rd_data,
    input logic [NUM_FLAGS-1:0] ev_vec,
    input logic [NUM_FLAGS-1:0] irq_en,
    input logic              men_set,
    input logic              men,
    input logic              irq
);
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[REG_W-1:NUM_FLAGS] == '0);

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_bit
        a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
            ev_vec[i] |=> rd_data[i]);
        a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
            (rd_data[i] && !(wr_en && !wr_data[i])) |=> rd_data[i]);
        a_r3_zero_clears: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !wr_data[i] && !ev_vec[i]) |=> !rd_data[i]);
        a_r3_no_spont_set: assert property (@(posedge clk) disable iff (rst)
            (!rd_data[i] && !ev_vec[i]) |=> !rd_data[i]);
    end

    a_r6_arb_drops_men: assert property (@(posedge clk) disable iff (rst)
        ev_vec[BIT_ARB] |=> (!men && rd_data[BIT_ARB]));
    a_r7_men_hold_low: assert property (@(posedge clk) disable iff (rst)
        (!men && !men_set) |=> !men);
    a_r8_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (irq_en == '0) |-> !irq);
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        (rd_data[NUM_FLAGS-1:0] == '0) |-> !irq);
    a_r9_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (rd_data == '0 && !men));
endmodule

bind i2cm_status i2cm_status_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .ev_vec  ({ev_nack, ev_arb_lost, ev_stop, ev_data_empty,
               ev_data_tx, ev_data_rx, ev_addr_tx}),
    .irq_en  (irq_en),
    .men_set (men_set),
    .men     (men),
    .irq     (irq)
);

// File: tb/i2cm_status_tb_top.sv
module i2cm_status_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [6:0]  ev = '0;
    logic [6:0]  irq_en = '0;
    logic        men_set = 1'b0;
    logic        men, irq;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cm_status dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ev_nack(ev[6]), .ev_arb_lost(ev[5]), .ev_stop(ev[4]),
        .ev_data_empty(ev[3]), .ev_data_tx(ev[2]), .ev_data_rx(ev[1]),
        .ev_addr_tx(ev[0]), .irq_en(irq_en), .men_set(men_set), .men(men), .irq(irq)
    );

    // {wr_en, wr_data[6:0], ev, irq_en, exp_rd[6:0], exp_irq}
    localparam logic [29:0] VEC [NVEC] = '{
        {1'b0, 7'h00, 7'h01, 7'h00, 7'h01, 1'b0},  // R2 R5 addr tx -> bit0
        {1'b0, 7'h00, 7'h08, 7'h08, 7'h09, 1'b1},  // R2 R5 data empty -> bit3
        {1'b0, 7'h00, 7'h00, 7'h01, 7'h09, 1'b1},  // R2 sticky
        {1'b1, 7'h7F, 7'h00, 7'h7F, 7'h09, 1'b1},  // R3 write 1 no change
        {1'b1, 7'h7E, 7'h00, 7'h01, 7'h08, 1'b0},  // R3 clear bit0 only
        {1'b1, 7'h77, 7'h08, 7'h08, 7'h08, 1'b1},  // R4 set wins
        {1'b1, 7'h00, 7'h50, 7'h40, 7'h50, 1'b1},  // R4 R5 nack/stop
        {1'b0, 7'h00, 7'h06, 7'h00, 7'h56, 1'b0},  // R5 tx/rx, R8 masked
        {1'b1, 7'h2F, 7'h00, 7'h04, 7'h06, 1'b1},  // R3 clear 6 and 4
        {1'b1, 7'h00, 7'h00, 7'h7F, 7'h00, 1'b0},  // R3 clear all, R8
        {1'b0, 7'h00, 7'h20, 7'h20, 7'h20, 1'b1}   // R5 R6 arb -> bit5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk); step(); step();
        rst = 1'b0;
        check("R9 reset rd", rd_data, 32'h0);
        check("R9 reset men", {31'b0, men}, 32'h0);

        for (int k = 0; k < NVEC; k++) begin
            wr_en   = VEC[k][29];
            wr_data = 32'hFFFF_FF80 | {25'b0, VEC[k][28:22]};
            ev      = VEC[k][21:15];
            irq_en  = VEC[k][14:8];
            step();
            ev = '0; wr_en = 1'b0;
            check($sformatf("R2/R3/R4/R5 vec %0d rd", k), rd_data, {25'b0, VEC[k][7:1]});
            check($sformatf("R1 vec %0d upper", k), {7'b0, rd_data[31:7]}, 32'h0);
            check($sformatf("R8 vec %0d irq", k), {31'b0, irq}, {31'b0, VEC[k][0]});
        end

        // R7: master enable only via men_set
        check("R7 men still 0 after table", {31'b0, men}, 32'h0);
        men_set = 1'b1; step(); men_set = 1'b0;
        check("R7 men set", {31'b0, men}, 32'h1);
        step();
        check("R7 men holds", {31'b0, men}, 32'h1);

        // R6: arbitration loss drops men and sets bit5
        wr_en = 1'b1; wr_data = 32'h0; step(); wr_en = 1'b0;
        ev = 7'h20; step(); ev = '0;
        check("R6 men dropped", {31'b0, men}, 32'h0);
        check("R6 bit5", rd_data, 32'h20);
        step(); step();
        check("R7 men stays 0", {31'b0, men}, 32'h0);

        // R7: simultaneous set and arb loss
        men_set = 1'b1; ev = 7'h20; step(); men_set = 1'b0; ev = '0;
        check("R7 arb beats set", {31'b0, men}, 32'h0);
        men_set = 1'b1; step(); men_set = 1'b0;
        check("R7 men re-set", {31'b0, men}, 32'h1);

        // R8: irq follows enable combinationally
        irq_en = 7'h20; #1;
        check("R8 irq on", {31'b0, irq}, 32'h1);
        irq_en = 7'h5F; #1;
        check("R8 irq off", {31'b0, irq}, 32'h0);

        // R9: reset with state present
        ev = 7'h7F; step(); ev = '0;
        check("R2 all set", rd_data, 32'h7F);
        rst = 1'b1; step(); rst = 1'b0;
        check("R9 flags cleared", rd_data, 32'h0);
        check("R9 men cleared", {31'b0, men}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule